// File: doc/BRIEF.md
# Serial Port Baud Tick Generator

This block turns the system clock into the two timing strobes an asynchronous serial port needs. A free-running down-counter is reloaded from an 8-bit divisor X. Each time it expires it produces a base event, so base events arrive every X+1 clocks. A phase counter then groups these base events into a bit-rate strobe for the transmitter and an oversampling strobe for the receiver's data-recovery logic.

Two inputs select how many base events make one bit. In asynchronous mode there is a low-speed setting (64 per bit) and a high-speed setting (16 per bit). In synchronous mode 4 base events make one bit and the speed input has no effect. Writing the divisor restarts the counter at once, so a new rate does not wait for the old period to finish. A change of the effective rate selection restarts the bit phase one clock later.

Top module: `baud_tick_gen`

## Requirements
- R1: A pulse on `div_we_i` loads `div_i` as the divisor X (0..255). The base timer then expires every X+1 clocks, and every bit strobe falls on a timer expiry.
- R2: In asynchronous low-speed mode (`sync_mode_i`=0, `high_speed_i`=0), `bit_tick_o` has a period of 64·(X+1) clocks and `os_tick_o` has a period of 4·(X+1) clocks.
- R3: In asynchronous high-speed mode (`sync_mode_i`=0, `high_speed_i`=1), `bit_tick_o` has a period of 16·(X+1) clocks and `os_tick_o` has a period of X+1 clocks.
- R4: In synchronous mode (`sync_mode_i`=1), `bit_tick_o` has a period of 4·(X+1) clocks, `os_tick_o` stays 0, and changing `high_speed_i` has no effect on the bit timing.
- R5: A divisor write restarts both the timer and the bit phase. Counting the first clock after the strobe edge as cycle 0, the first `os_tick_o` comes in cycle D·(X+1)−1, where D is 4 for low speed and 1 for high speed. The first `bit_tick_o` comes in cycle M·(X+1)−1, where M is 64, 16 or 4.
- R6: Each strobe lasts one clock. `bit_tick_o` is never high in two consecutive cycles, and in asynchronous mode every `bit_tick_o` coincides with an `os_tick_o`.
- R7: After reset the divisor is 0 and asynchronous low speed is selected, so `bit_tick_o` repeats every 64 clocks and `os_tick_o` every 4 clocks. Both strobes are 0 while reset is asserted.
- R8: A change of the effective rate selection, seen at a clock edge, clears the bit phase at that edge without touching the timer. With X=0 the first `bit_tick_o` then comes in cycle M−1 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | 8 | Divisor value X |
| div_we_i | input | 1 | Divisor write strobe, one clock |
| high_speed_i | input | 1 | 1 = 16 base events per bit in asynchronous mode |
| sync_mode_i | input | 1 | 1 = synchronous mode, 4 base events per bit |
| os_tick_o | output | 1 | Receiver oversampling strobe, 16 per bit in asynchronous mode |
| bit_tick_o | output | 1 | Bit-rate strobe |

## Verification
The assertions check on every cycle that the timer stays within the loaded divisor and reloads after expiry, and that a write lands in the counter. They also check that the phase never passes its terminal value, that strobes are single-cycle, that every bit strobe aligns with an oversample strobe, and that synchronous mode is quiet on the oversample output. Only the bench scenarios can show the actual periods and first-strobe positions for each rate and divisor. The same holds for the restart timing after writes and mode changes, and for the fact that the speed input is ignored in synchronous mode.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic [1:0] {
    RATE_LOW  = 2'd0,
    RATE_HIGH = 2'd1,
    RATE_SYNC = 2'd2
  } rate_e;

  function automatic rate_e rate_sel(input logic sync_mode, input logic high_speed);
    if (sync_mode) return RATE_SYNC;
    if (high_speed) return RATE_HIGH;
    return RATE_LOW;
  endfunction
endpackage

// File: rtl/baud_timer.sv
module baud_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             div_we_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] div_q, cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (div_we_i) begin
      div_q <= div_i;
      cnt_q <= div_i;
    end else if (cnt_q == '0) begin
      cnt_q <= div_q;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign tick_o = (cnt_q == '0);

  assert_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_we_i |=> cnt_q == $past(div_i));
  assert_cnt_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= div_q);
  assert_reload_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !div_we_i) |=> cnt_q == div_q);
endmodule

// File: rtl/baud_mode.sv
module baud_mode
  import baud_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sync_mode_i,
  input  logic  high_speed_i,
  output rate_e rate_o,
  output logic  change_o
);
  rate_e rate_q, rate_d;

  assign rate_d = rate_sel(sync_mode_i, high_speed_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rate_q <= RATE_LOW;
    else         rate_q <= rate_d;
  end

  assign rate_o   = rate_q;
  assign change_o = (rate_d != rate_q);

  assert_mode_follow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    change_o |=> rate_q != $past(rate_q));
endmodule

// File: rtl/baud_phase.sv
module baud_phase
  import baud_pkg::*;
#(
  parameter int LOW_MULT  = 64,
  parameter int HIGH_MULT = 16,
  parameter int SYNC_MULT = 4
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  base_tick_i,
  input  logic  clear_i,
  input  rate_e rate_i,
  output logic  os_tick_o,
  output logic  bit_tick_o
);
  localparam int PH_W  = $clog2(LOW_MULT);
  localparam int PRE   = LOW_MULT / HIGH_MULT;
  localparam int PRE_W = (PRE > 1) ? $clog2(PRE) : 1;

  logic [PH_W-1:0] ph_q, term;
  logic            at_term, pre_hit;

  always_comb begin
    case (rate_i)
      RATE_SYNC: term = PH_W'(SYNC_MULT - 1);
      RATE_HIGH: term = PH_W'(HIGH_MULT - 1);
      default:   term = PH_W'(LOW_MULT - 1);
    endcase
  end

  assign at_term = (ph_q == term);

  generate
    if (PRE > 1) begin : g_pre
      assign pre_hit = (ph_q[PRE_W-1:0] == {PRE_W{1'b1}});
    end else begin : g_nopre
      assign pre_hit = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ph_q <= '0;
    else if (clear_i)     ph_q <= '0;
    else if (base_tick_i) ph_q <= at_term ? '0 : ph_q + 1'b1;
  end

  always_comb begin
    case (rate_i)
      RATE_LOW:  os_tick_o = base_tick_i && pre_hit;
      RATE_HIGH: os_tick_o = base_tick_i;
      default:   os_tick_o = 1'b0;
    endcase
  end

  assign bit_tick_o = base_tick_i && at_term;

  assert_phase_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q <= term);
  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> ph_q == '0);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int LOW_MULT  = 64,
  parameter int HIGH_MULT = 16,
  parameter int SYNC_MULT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             div_we_i,
  input  logic             high_speed_i,
  input  logic             sync_mode_i,
  output logic             os_tick_o,
  output logic             bit_tick_o
);
  logic  base_tick, mode_chg;
  rate_e rate;

  baud_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .div_i    (div_i),
    .div_we_i (div_we_i),
    .tick_o   (base_tick)
  );

  baud_mode u_mode (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sync_mode_i  (sync_mode_i),
    .high_speed_i (high_speed_i),
    .rate_o       (rate),
    .change_o     (mode_chg)
  );

  baud_phase #(
    .LOW_MULT  (LOW_MULT),
    .HIGH_MULT (HIGH_MULT),
    .SYNC_MULT (SYNC_MULT)
  ) u_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .base_tick_i (base_tick),
    .clear_i     (div_we_i || mode_chg),
    .rate_i      (rate),
    .os_tick_o   (os_tick_o),
    .bit_tick_o  (bit_tick_o)
  );

  assert_bit_on_base_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> base_tick);
  assert_bit_one_cycle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |=> !bit_tick_o);
  assert_bit_on_os_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_tick_o && rate != RATE_SYNC) |-> os_tick_o);
  assert_sync_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate == RATE_SYNC) |-> !os_tick_o);
endmodule

// File: tb/sim_baud_tick_gen.sv
`timescale 1ns/1ps
module sim_baud_tick_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] div;
  logic       we, hs, sm;
  logic       os_tick, bit_tick;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  baud_tick_gen u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .div_i        (div),
    .div_we_i     (we),
    .high_speed_i (hs),
    .sync_mode_i  (sm),
    .os_tick_o    (os_tick),
    .bit_tick_o   (bit_tick)
  );

  function automatic int bit_mult(bit s, bit h);
    return s ? 4 : (h ? 16 : 64);
  endfunction

  function automatic int os_div(bit h);
    return h ? 1 : 4;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // do_write: load divisor x; otherwise only the mode inputs change
  task automatic run(int x, bit s, bit h, bit do_write, bit chk_first, string tag);
    int b0 = -1, b1 = -1, o0 = -1, o1 = -1, oc = 0, bad = 0;
    bit prev = 1'b0;
    int m = bit_mult(s, h);
    int d = os_div(h);
    int lim = 2 * m * (x + 1) + 16;
    string rq = (tag != "") ? tag : (s ? "R4" : (h ? "R3" : "R2"));
    @(negedge clk);
    sm = s; hs = h;
    if (do_write) begin div = 8'(x); we = 1'b1; end
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
    for (int c = 0; c < lim; c++) begin
      if (bit_tick) begin
        if (b0 < 0) b0 = c; else if (b1 < 0) b1 = c;
        if (prev) bad++;
        if (!s && !os_tick) bad++;
      end
      if (os_tick) begin
        oc++;
        if (o0 < 0) o0 = c; else if (o1 < 0) o1 = c;
      end
      prev = bit_tick;
      @(negedge clk);
    end
    if (chk_first) check(b0 == m*(x+1)-1, (tag != "") ? tag : "R5", "first bit tick", b0, m*(x+1)-1);
    check(b1 - b0 == m*(x+1), rq, "bit period", b1 - b0, m*(x+1));
    check(bad == 0, "R6", "strobe width/alignment errors", bad, 0);
    if (s) begin
      check(oc == 0, "R4", "os ticks in sync mode", oc, 0);
    end else begin
      check(o1 - o0 == d*(x+1), h ? "R1" : rq, "os period", o1 - o0, d*(x+1));
      if (chk_first) check(o0 == d*(x+1)-1, (tag != "") ? tag : "R5", "first os tick", o0, d*(x+1)-1);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; we = 1'b0; div = '0; hs = 1'b0; sm = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!os_tick && !bit_tick, "R7", "ticks during reset", int'(os_tick) + int'(bit_tick), 0);
    rst_n = 1'b1;
    // R7: reset defaults, no write
    run(0, 0, 0, 0, 0, "R7");
    // R1/R3 corner divisors
    run(0, 0, 1, 1, 1, "");
    run(255, 0, 1, 1, 1, "");
    // R5: rewrite mid-period with the same value
    run(20, 0, 1, 1, 1, "");
    run(20, 0, 1, 1, 1, "R5");
    for (int i = 0; i < 3; i++) run(int'($urandom % 48), 0, 0, 1, 1, "");
    for (int i = 0; i < 3; i++) run(int'($urandom % 256), 0, 1, 1, 1, "");
    for (int i = 0; i < 3; i++) run(int'($urandom % 256), 1, 0, 1, 1, "");
    // R4: speed input toggled in sync mode is ignored
    run(5, 1, 0, 1, 1, "");
    run(5, 1, 1, 0, 0, "R4");
    // R8: mode change alone restarts phase (X=0)
    run(0, 0, 0, 1, 1, "");
    run(0, 0, 1, 0, 1, "R8");
    run(0, 1, 1, 0, 1, "R8");
    run(0, 0, 0, 0, 1, "R8");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule